// File: doc/BRIEF.md
# Write Protection Sequence Guard

This block sits between the byte-load decoder and the page write controller of a nonvolatile array. Every load of a page window passes through it. A load is either taken as a step of a command sequence or passed on as page data. When the load window closes, the guard says whether the internal write timer starts and whether the loaded page may change the array. It keeps a protection flag that only a storage power-on clear can reset. The ordinary logic reset leaves the flag alone, so protection survives a power cycle of the control logic.

Three loads open the window and unlock it: address 0x5555 with data 0xAA, then 0x2AAA with 0x55, then 0x5555 with 0xA0. This prefix sets protection if it was off and lets the page of the current window commit. A six-load sequence turns protection off: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20. A protected window without the prefix still starts the write timer but commits nothing. Writes are locked out while the supply indication is low and for `LOCK_CYCLES` clocks after it rises. A load that arrives in the same cycle as `window_end` is dropped.

The recogniser uses these states. IDLE is the start of a window. GOT1 and GOT2 mean one or two prefix steps have been taken. DIS3, DIS4 and DIS5 follow the 0x80, 0xAA and 0x55 steps of the disable sequence. PAGE means command recognition is over for the window. The transitions are:
- IDLE to GOT1 on the first step.
- GOT1 to GOT2 on the second step.
- GOT2 to PAGE on 0xA0, which unlocks the window.
- GOT2 to DIS3, DIS3 to DIS4 and DIS4 to DIS5 on the matching disable steps.
- DIS5 to PAGE on 0x20, which disables protection.
- Any state to PAGE on a mismatching load.
- Any state to IDLE on window end or on lockout.

Top module: `wprot_guard`

## Requirements
- R1: `prot_on` is 0 after `por_n` has been low across a clock edge, and a pulse on `rst_n` alone leaves `prot_on` unchanged.
- R2: While `supply_ok` is low, and for `LOCK_CYCLES` clocks after it rises, loads are ignored. They raise no `cmd_consumed` and no `timer_start`. A drop of `supply_ok` in mid-window discards the loads of that window.
- R3: The loads 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, taken as the first three of a window, each raise `cmd_consumed` for one cycle after the load. `prot_on` reads 1 from the cycle after the third load.
- R4: A protected window that begins with the unlock prefix and holds data raises `timer_start` and `commit_allowed` together for one cycle after `window_end`.
- R5: A protected window with data but without the complete prefix raises `timer_start` with `commit_allowed` low.
- R6: An unprotected window with data raises both `timer_start` and `commit_allowed`.
- R7: The six-load disable sequence clears `prot_on` from the cycle after its sixth load. Data in the rest of that window commits.
- R8: A load that does not match the expected step is not consumed and counts as page data. No later load of that window is consumed.
- R9: A window that holds no data loads, whether it has only command loads or no loads at all, raises neither `timer_start` nor `commit_allowed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low logic reset; does not touch the protection flag |
| por_n | input | 1 | Active-low storage power-on clear of the protection flag |
| supply_ok | input | 1 | Supply above its sense level |
| load_valid | input | 1 | One decoded byte load this cycle |
| load_addr | input | ADDR_W | Address of the load |
| load_data | input | DATA_W | Data of the load |
| window_end | input | 1 | Load window has closed |
| cmd_consumed | output | 1 | The previous load was taken as a command step |
| timer_start | output | 1 | Internal write timer starts |
| commit_allowed | output | 1 | Loaded page may change the array |
| prot_on | output | 1 | Protection flag |

## Verification
The hardest situation to reach is a window whose command prefix breaks at a late step, such as the fourth or fifth step of the disable sequence. Such a window must still count as a data window, and its verdict depends on the persistent flag left behind by earlier windows. Random windows start from a chosen sequence and corrupt each step with a fixed probability, so that partial prefixes of every length occur. Each window is followed by random data loads. Directed cases cover a mismatch at a fixed step, a supply drop in mid-window, the lockout and the storage clear. The protection flag is carried from one window to the next throughout.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE, SEQ_GOT1, SEQ_GOT2, SEQ_DIS3, SEQ_DIS4, SEQ_DIS5, SEQ_PAGE
    } seq_state_t;

    localparam logic [7:0] CODE_FIRST   = 8'hAA;
    localparam logic [7:0] CODE_SECOND  = 8'h55;
    localparam logic [7:0] CODE_UNLOCK  = 8'hA0;
    localparam logic [7:0] CODE_DIS_ESC = 8'h80;
    localparam logic [7:0] CODE_DISABLE = 8'h20;
endpackage

// File: rtl/wprot_lockout.sv
module wprot_lockout #(
    parameter int LOCK_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic wr_ok
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LOCK_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!supply_ok) cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign wr_ok = supply_ok && (cnt == LIM);
endmodule

// File: rtl/wprot_flag.sv
module wprot_flag (
    input  logic clk,
    input  logic por_n,
    input  logic set_req,
    input  logic clr_req,
    output logic prot_q
);
    // Cleared only by the storage power-on input, never by logic reset.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       prot_q <= 1'b0;
        else if (set_req) prot_q <= 1'b1;
        else if (clr_req) prot_q <= 1'b0;
    end
endmodule

// File: rtl/wprot_seqfsm.sv
module wprot_seqfsm
    import wprot_pkg::*;
#(
    parameter int                ADDR_W = 15,
    parameter int                DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_A = 15'h5555,
    parameter logic [ADDR_W-1:0] ADDR_B = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              win_end,
    input  logic              prot_on,
    output logic              set_prot,
    output logic              clr_prot,
    output logic              cmd_hit,
    output logic              timer_go,
    output logic              commit_go
);
    seq_state_t state, nxt;
    logic unlocked, data_seen, step_hit, load_ev, data_ld, close_win;

    wire at_a = (ld_addr == ADDR_A);
    wire at_b = (ld_addr == ADDR_B);
    wire is_aa  = at_a && (ld_data == DATA_W'(CODE_FIRST));
    wire is_55  = at_b && (ld_data == DATA_W'(CODE_SECOND));
    wire is_a0  = at_a && (ld_data == DATA_W'(CODE_UNLOCK));
    wire is_80  = at_a && (ld_data == DATA_W'(CODE_DIS_ESC));
    wire is_20  = at_a && (ld_data == DATA_W'(CODE_DISABLE));

    assign close_win = !wr_ok || win_end;
    assign load_ev   = wr_ok && ld_valid && !win_end;
    assign data_ld   = load_ev && !step_hit;

    always_comb begin
        nxt      = state;
        step_hit = 1'b0;
        set_prot = 1'b0;
        clr_prot = 1'b0;
        if (close_win) begin
            nxt = SEQ_IDLE;
        end else if (ld_valid) begin
            nxt = SEQ_PAGE;
            unique case (state)
                SEQ_IDLE: if (is_aa) begin nxt = SEQ_GOT1; step_hit = 1'b1; end
                SEQ_GOT1: if (is_55) begin nxt = SEQ_GOT2; step_hit = 1'b1; end
                SEQ_GOT2: begin
                    if (is_a0) begin
                        step_hit = 1'b1;
                        set_prot = 1'b1;
                    end else if (is_80) begin
                        nxt = SEQ_DIS3;
                        step_hit = 1'b1;
                    end
                end
                SEQ_DIS3: if (is_aa) begin nxt = SEQ_DIS4; step_hit = 1'b1; end
                SEQ_DIS4: if (is_55) begin nxt = SEQ_DIS5; step_hit = 1'b1; end
                SEQ_DIS5: begin
                    if (is_20) begin
                        step_hit = 1'b1;
                        clr_prot = 1'b1;
                    end
                end
                SEQ_PAGE: nxt = SEQ_PAGE;
                default:  nxt = SEQ_IDLE;
            endcase
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            unlocked  <= 1'b0;
            data_seen <= 1'b0;
        end else begin
            state <= nxt;
            if (close_win) begin
                unlocked  <= 1'b0;
                data_seen <= 1'b0;
            end else begin
                if (set_prot) unlocked  <= 1'b1;
                if (data_ld)  data_seen <= 1'b1;
            end
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_hit   <= 1'b0;
            timer_go  <= 1'b0;
            commit_go <= 1'b0;
        end else begin
            cmd_hit   <= step_hit;
            timer_go  <= wr_ok && win_end && data_seen;
            commit_go <= wr_ok && win_end && data_seen && (!prot_on || unlocked);
        end
    end
endmodule

// File: rtl/wprot_guard.sv
module wprot_guard #(
    parameter int                ADDR_W      = 15,
    parameter int                DATA_W      = 8,
    parameter int                LOCK_CYCLES = 200,
    parameter logic [ADDR_W-1:0] ADDR_A      = 15'h5555,
    parameter logic [ADDR_W-1:0] ADDR_B      = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              supply_ok,
    input  logic              load_valid,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              window_end,
    output logic              cmd_consumed,
    output logic              timer_start,
    output logic              commit_allowed,
    output logic              prot_on
);
    logic wr_ok, set_req, clr_req;

    wprot_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lockout (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wr_ok(wr_ok)
    );

    wprot_seqfsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
        .ld_valid(load_valid), .ld_addr(load_addr), .ld_data(load_data),
        .win_end(window_end), .prot_on(prot_on),
        .set_prot(set_req), .clr_prot(clr_req),
        .cmd_hit(cmd_consumed), .timer_go(timer_start), .commit_go(commit_allowed)
    );

    wprot_flag u_flag (
        .clk(clk), .por_n(por_n), .set_req(set_req), .clr_req(clr_req), .prot_q(prot_on)
    );
endmodule

// File: rtl/wprot_guard_chk.sv
module wprot_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic por_n,
    input logic supply_ok,
    input logic load_valid,
    input logic window_end,
    input logic cmd_consumed,
    input logic timer_start,
    input logic commit_allowed,
    input logic prot_on
);
    assert_commit_needs_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_allowed |-> timer_start);

    assert_lockout_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!cmd_consumed && !timer_start));

    assert_consumed_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_consumed |-> $past(load_valid));

    assert_prot_rise_by_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(prot_on) |-> cmd_consumed);

    assert_prot_fall_by_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $fell(prot_on) |-> cmd_consumed);

    assert_timer_after_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timer_start |-> $past(window_end));
endmodule

bind wprot_guard wprot_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .supply_ok(supply_ok),
    .load_valid(load_valid), .window_end(window_end),
    .cmd_consumed(cmd_consumed), .timer_start(timer_start),
    .commit_allowed(commit_allowed), .prot_on(prot_on)
);

// File: tb/wprot_guard_bench.sv
module wprot_guard_bench;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;
    localparam int LOCK   = 200;
    localparam logic [ADDR_W-1:0] A = 15'h5555;
    localparam logic [ADDR_W-1:0] B = 15'h2AAA;

    logic clk = 1'b0, rst_n = 1'b0, por_n = 1'b0, supply_ok = 1'b0;
    logic load_valid = 1'b0, window_end = 1'b0;
    logic [ADDR_W-1:0] load_addr = '0;
    logic [DATA_W-1:0] load_data = '0;
    logic cmd_consumed, timer_start, commit_allowed, prot_on;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // bench model of the window
    int  n_ld;
    bit  unl_ok, dis_ok, unlocked, data_seen, exp_prot;

    always #4 clk = ~clk;

    wprot_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_CYCLES(LOCK)) u_wprot_guard (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .supply_ok(supply_ok),
        .load_valid(load_valid), .load_addr(load_addr), .load_data(load_data),
        .window_end(window_end), .cmd_consumed(cmd_consumed), .timer_start(timer_start),
        .commit_allowed(commit_allowed), .prot_on(prot_on)
    );

    function automatic bit unl_step(int i, logic [ADDR_W-1:0] a, logic [7:0] d);
        case (i)
            0: return a == A && d == 8'hAA;
            1: return a == B && d == 8'h55;
            2: return a == A && d == 8'hA0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit dis_step(int i, logic [ADDR_W-1:0] a, logic [7:0] d);
        case (i)
            0, 3: return a == A && d == 8'hAA;
            1, 4: return a == B && d == 8'h55;
            2: return a == A && d == 8'h80;
            5: return a == A && d == 8'h20;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string tag, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, got, exp);
        end
    endtask

    task automatic new_window();
        n_ld = 0; unl_ok = 1; dis_ok = 1; unlocked = 0; data_seen = 0;
    endtask

    task automatic do_load(string tag, logic [ADDR_W-1:0] a, logic [7:0] d);
        bit u, s, cons;
        @(negedge clk);
        load_valid = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_valid = 1'b0;
        u = unl_ok && unl_step(n_ld, a, d);
        s = dis_ok && dis_step(n_ld, a, d);
        cons = u || s;
        unl_ok = u; dis_ok = s;
        if (u && n_ld == 2) begin unlocked = 1; exp_prot = 1; end
        if (s && n_ld == 5) exp_prot = 0;
        if (!cons) begin data_seen = 1; unl_ok = 0; dis_ok = 0; end
        n_ld++;
        check(tag, "cmd_consumed", cmd_consumed, cons);
        check(tag, "prot_on", prot_on, exp_prot);
    endtask

    task automatic load_ignored(string tag, logic [ADDR_W-1:0] a, logic [7:0] d);
        @(negedge clk);
        load_valid = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_valid = 1'b0;
        check(tag, "ignored cmd_consumed", cmd_consumed, 1'b0);
        check(tag, "ignored prot_on", prot_on, exp_prot);
    endtask

    task automatic end_window(string tag);
        @(negedge clk);
        window_end = 1'b1;
        @(negedge clk);
        window_end = 1'b0;
        check(tag, "timer_start", timer_start, data_seen);
        check(tag, "commit_allowed", commit_allowed, data_seen && (!exp_prot || unlocked));
        new_window();
    endtask

    task automatic send_unlock(string tag);
        do_load(tag, A, 8'hAA); do_load(tag, B, 8'h55); do_load(tag, A, 8'hA0);
    endtask

    task automatic wait_cycles(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [ADDR_W+7:0] pattern(int mode, int i);
        case (mode)
            0, 3: case (i) 0: return {A, 8'hAA}; 1: return {B, 8'h55}; default: return {A, 8'hA0}; endcase
            default: case (i)
                0, 3: return {A, 8'hAA};
                1, 4: return {B, 8'h55};
                2: return {A, 8'h80};
                default: return {A, 8'h20};
            endcase
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        exp_prot = 0;
        new_window();
        wait_cycles(3);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "reset prot_on", prot_on, 1'b0);
        check("R1", "reset timer_start", timer_start, 1'b0);
        check("R1", "reset commit_allowed", commit_allowed, 1'b0);
        check("R1", "reset cmd_consumed", cmd_consumed, 1'b0);

        // R2: lockout while supply low, then during the delay
        load_ignored("R2", A, 8'hAA);
        supply_ok = 1'b1;
        wait_cycles(20);
        load_ignored("R2", A, 8'hAA);
        load_ignored("R2", 15'h0123, 8'h3C);
        end_window("R2");
        wait_cycles(LOCK + 5);

        // R6: unprotected data commits
        do_load("R6", 15'h0040, 8'h11);
        do_load("R6", 15'h0041, 8'h22);
        end_window("R6");

        // R3 and R4: unlock prefix sets protection, page commits
        send_unlock("R3");
        do_load("R4", 15'h0100, 8'h5A);
        end_window("R4");

        // R5: protected data without prefix
        do_load("R5", 15'h0200, 8'h77);
        end_window("R5");

        // R8: mismatch at step two, later steps not recognised
        do_load("R8", A, 8'hAA);
        do_load("R8", A, 8'h55);
        do_load("R8", A, 8'hA0);
        end_window("R8");

        // R9: commands only, no data
        send_unlock("R9");
        end_window("R9");
        end_window("R9");

        // R1: logic reset keeps the flag
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1", "prot_on after rst_n", prot_on, 1'b1);
        wait_cycles(LOCK + 5);

        // R7: disable sequence then data
        do_load("R7", A, 8'hAA); do_load("R7", B, 8'h55); do_load("R7", A, 8'h80);
        do_load("R7", A, 8'hAA); do_load("R7", B, 8'h55); do_load("R7", A, 8'h20);
        do_load("R7", 15'h0300, 8'h99);
        end_window("R7");

        // random windows, R3 R5 R7 R8 R9
        for (int w = 0; w < 400; w++) begin
            int mode, steps, ndata;
            mode  = $urandom % 4;
            steps = (mode == 1) ? 6 : (mode == 2) ? 0 : 3;
            ndata = $urandom % 3;
            for (int i = 0; i < steps; i++) begin
                logic [ADDR_W+7:0] p;
                p = pattern(mode, i);
                if ($urandom % 7 == 0) p[7:0] = p[7:0] ^ 8'h01;
                do_load("R8", p[ADDR_W+7:8], p[7:0]);
            end
            for (int i = 0; i < ndata; i++) begin
                logic [ADDR_W-1:0] ra;
                ra = ($urandom % 2 == 0) ? A : ADDR_W'($urandom);
                do_load("R5", ra, 8'($urandom));
            end
            if ($urandom % 2 == 0) wait_cycles(1);
            end_window("R9");
        end

        // R2: supply drop in mid-window discards the window
        do_load("R2", 15'h0400, 8'h44);
        @(negedge clk); supply_ok = 1'b0;
        @(negedge clk); supply_ok = 1'b1;
        new_window();
        wait_cycles(LOCK + 5);
        end_window("R2");

        // R1: storage clear resets the flag
        send_unlock("R1");
        end_window("R1");
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        exp_prot = 0;
        check("R1", "prot_on after por_n", prot_on, 1'b0);

        done = 1'b1;
        report();
    end
endmodule